// File: doc/BRIEF.md
# Dual-channel output compare waveform generator

The block turns a shared triangle or sawtooth counter into two waveform outputs, `rt0_o` and `rt1_o`. Each channel owns a compare register. On every clock the counter value supplied from outside is compared with both registers. The output of each channel then either toggles or moves to a defined level, according to that channel's mode. The counter itself is outside the block. The block receives the count value, the count direction and one-cycle flags marking the zero and peak points of the count.

Each channel's mode is one of the following:
- single-change toggling;
- a two-change mode, on channel 1 only, in which both compare registers toggle `rt1_o`;
- an up/down mode with an active-high output;
- an up/down mode with an active-low output.

In the up/down modes the output is driven active when a match happens while counting up, and inactive when a match happens while counting down. The two extreme compare values hold the output at a constant level.

Each compare register may be written directly. It may also be written through a shadow copy, which moves into the working register on the counter's zero flag or on its peak flag, as chosen per channel. This lets software change the compare values of both channels at a common, glitch-free point of the count.

Top module: `ocu_wave_gen`

## Requirements
- R1: While reset is asserted and after it is released, each channel's internal state is inactive. The outputs are therefore 0 in modes 00, 01 and 10, and 1 in mode 11. Both compare registers reset to 0x0000.
- R2: In mode 00 (single-change), an output inverts on the clock edge that follows a cycle in which `cnt_i` equals that channel's compare value. `cnt_up_i`, `zero_i` and `peak_i` have no effect on this, and the two channels work independently.
- R3: With `mode1_i` = 01 (two-change), `rt1_o` inverts after any cycle in which `cnt_i` equals compare value 0 or compare value 1. When both compare values are equal, it inverts only once.
- R4: While `mode1_i` = 01, channel 0 runs as single-change and its own `mode0_i` is ignored.
- R5: `mode0_i` = 01 makes channel 0 behave as single-change.
- R6: In modes 10 and 11, with a compare value other than 0x0000 and 0xFFFF, the output goes active after a match cycle with `cnt_up_i` = 1 and inactive after a match cycle with `cnt_up_i` = 0. A match in a cycle with `peak_i` = 1 leaves the output unchanged.
- R7: In modes 10 and 11, a compare value of 0x0000 drives the output active one cycle later, and a compare value of 0xFFFF drives it inactive one cycle later. Each level is held for as long as that compare value remains.
- R8: The active level is 0 in mode 11 and 1 in every other mode. A change of the mode input takes effect on the output level at once, without any clock edge.
- R9: With `buf_en_i[c]` = 0, a write on `wr_en_i[c]` takes effect as the compare value from the next cycle onward.
- R10: With `buf_en_i[c]` = 1, a write goes only to the shadow register. The shadow is copied into the compare register after a cycle with `zero_i` = 1 when `xfer_peak_i[c]` = 0, or after a cycle with `peak_i` = 1 when `xfer_peak_i[c]` = 1. A write in the transfer cycle itself is the value that gets transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CW | Counter value |
| cnt_up_i | input | 1 | 1 while counting up, 0 while counting down |
| zero_i | input | 1 | Counter is at its zero point this cycle |
| peak_i | input | 1 | Counter is at its peak point this cycle |
| mode0_i | input | 2 | Channel 0 mode (00 single, 01 behaves as 00, 10 up/down high, 11 up/down low) |
| mode1_i | input | 2 | Channel 1 mode (00 single, 01 two-change, 10 up/down high, 11 up/down low) |
| buf_en_i | input | 2 | Per channel: route writes through the shadow register |
| xfer_peak_i | input | 2 | Per channel: shadow transfer point, 0 = zero flag, 1 = peak flag |
| wr_en_i | input | 2 | Per channel write strobe |
| wr_data0_i | input | CW | Write data for channel 0 |
| wr_data1_i | input | CW | Write data for channel 1 |
| rt0_o | output | 1 | Channel 0 waveform |
| rt1_o | output | 1 | Channel 1 waveform |

## Verification
The bench drives a triangle counter through every pair of channel modes and compares each output on every cycle against a model built from the requirements.

It aims at the following corner cases, each paired with the fault it would expose:
- A match on the peak count, which arrives while the direction reads down. A design that ignores the peak hold would drop the output there.
- Equal compare values in two-change mode. A design that adds the two matches would toggle twice, which cancels out to no toggle.
- The saturating values 0x0000 and 0xFFFF. A design that treats these as ordinary matches would only change at the zero point, or would never change.
- Channel 0 set to an up/down mode while channel 1 runs two-change. A design that fails to tie channel 0 to single-change would show a level pattern on `rt0_o` instead of toggles.
- Shadow writes that land exactly on the transfer cycle. A design with the wrong priority would load the stale shadow and lag one period behind.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_DUAL   = 2'b01,
    MODE_UD_HI  = 2'b10,
    MODE_UD_LO  = 2'b11
  } ocu_mode_e;
endpackage

// File: rtl/ocu_cmp_buf.sv
module ocu_cmp_buf #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          buf_en_i,
  input  logic          xfer_peak_i,
  input  logic          zero_i,
  input  logic          peak_i,
  output logic [CW-1:0] cmp_o
);
  logic [CW-1:0] shadow_q;
  logic [CW-1:0] active_q;
  logic          xfer_ev;

  assign xfer_ev = buf_en_i & (xfer_peak_i ? peak_i : zero_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (wr_en_i) begin
      shadow_q <= wr_data_i;
    end
  end

  // a write in the transfer cycle wins over the older shadow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
    end else if (wr_en_i && !buf_en_i) begin
      active_q <= wr_data_i;
    end else if (xfer_ev) begin
      active_q <= wr_en_i ? wr_data_i : shadow_q;
    end
  end

  assign cmp_o = active_q;

  AST_UNBUF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !buf_en_i) |=> (cmp_o == $past(wr_data_i))); // R9

  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_en_i && !(xfer_peak_i ? peak_i : zero_i)) |=> $stable(cmp_o)); // R10
endmodule

// File: rtl/ocu_wave_ch.sv
module ocu_wave_ch
  import ocu_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ocu_mode_e     mode_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          cnt_up_i,
  input  logic          peak_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          match_other_i,
  output logic          match_o,
  output logic          wave_o
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic act_q;
  logic act_d;
  logic ud;
  logic lo_sat;
  logic hi_sat;
  logic hit;

  assign match_o = (cnt_i == cmp_i);
  assign ud      = mode_i[1];
  assign lo_sat  = (cmp_i == '0);
  assign hi_sat  = (cmp_i == MAXV);
  assign hit     = match_o | ((mode_i == MODE_DUAL) & match_other_i);

  always_comb begin
    act_d = act_q;
    if (!ud) begin
      act_d = act_q ^ hit;
    end else if (lo_sat) begin
      act_d = 1'b1;
    end else if (hi_sat) begin
      act_d = 1'b0;
    end else if (match_o && !peak_i) begin
      act_d = cnt_up_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_d;
  end

  assign wave_o = act_q ^ (mode_i == MODE_UD_LO);

  AST_SAT_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ud && lo_sat) |=> act_q); // R7

  AST_SAT_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ud && hi_sat) |=> !act_q); // R7

  AST_PEAK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ud && !lo_sat && !hi_sat && peak_i) |=> $stable(act_q)); // R6

  AST_TGL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ud && (cnt_i != cmp_i) && !((mode_i == MODE_DUAL) && match_other_i))
      |=> $stable(act_q)); // R2
endmodule

// File: rtl/ocu_wave_gen.sv
module ocu_wave_gen
  import ocu_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          cnt_up_i,
  input  logic          zero_i,
  input  logic          peak_i,
  input  logic [1:0]    mode0_i,
  input  logic [1:0]    mode1_i,
  input  logic [1:0]    buf_en_i,
  input  logic [1:0]    xfer_peak_i,
  input  logic [1:0]    wr_en_i,
  input  logic [CW-1:0] wr_data0_i,
  input  logic [CW-1:0] wr_data1_i,
  output logic          rt0_o,
  output logic          rt1_o
);
  localparam int NCH = 2;

  logic [CW-1:0] wr_data [NCH];
  logic [CW-1:0] cmp     [NCH];
  logic [NCH-1:0] match;
  ocu_mode_e mode_ch0;
  ocu_mode_e mode_ch1;

  assign wr_data[0] = wr_data0_i;
  assign wr_data[1] = wr_data1_i;

  // two-change on ch1 ties ch0 to single-change; 01 on ch0 is single-change
  assign mode_ch1 = ocu_mode_e'(mode1_i);
  assign mode_ch0 = (mode_ch1 == MODE_DUAL || mode0_i == 2'b01) ?
                    MODE_SINGLE : ocu_mode_e'(mode0_i);

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    ocu_cmp_buf #(.CW(CW)) u_cmp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i[c]),
      .wr_data_i   (wr_data[c]),
      .buf_en_i    (buf_en_i[c]),
      .xfer_peak_i (xfer_peak_i[c]),
      .zero_i      (zero_i),
      .peak_i      (peak_i),
      .cmp_o       (cmp[c])
    );
  end

  ocu_wave_ch #(.CW(CW)) u_ch0 (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode_ch0),
    .cnt_i         (cnt_i),
    .cnt_up_i      (cnt_up_i),
    .peak_i        (peak_i),
    .cmp_i         (cmp[0]),
    .match_other_i (1'b0),
    .match_o       (match[0]),
    .wave_o        (rt0_o)
  );

  ocu_wave_ch #(.CW(CW)) u_ch1 (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode_ch1),
    .cnt_i         (cnt_i),
    .cnt_up_i      (cnt_up_i),
    .peak_i        (peak_i),
    .cmp_i         (cmp[1]),
    .match_other_i (match[0]),
    .match_o       (match[1]),
    .wave_o        (rt1_o)
  );

  AST_DUAL_TGL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode1_i == 2'b01 && (cnt_i == cmp[0]) && (mode1_i == $past(mode1_i)))
      |=> (rt1_o != $past(rt1_o)) || (mode1_i != $past(mode1_i))); // R3

  AST_CH0_TIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode1_i == 2'b01 && cnt_i != cmp[0] && $stable(mode1_i))
      |=> $stable(rt0_o) || (mode1_i != $past(mode1_i))); // R4
endmodule

// File: tb/ocu_wave_gen_tb_top.sv
module ocu_wave_gen_tb_top;
  localparam int CLK_P = 10;
  localparam int CW    = 16;
  localparam int PEAK  = 24;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic up = 1'b1, zero = 1'b0, peak = 1'b0;
  logic [1:0] mode0 = 2'b00, mode1 = 2'b00;
  logic [1:0] buf_en = 2'b00, xfer_pk = 2'b00, wr_en = 2'b00;
  logic [CW-1:0] wd0 = '0, wd1 = '0;
  logic rt0, rt1;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string phase = "";

  logic          m_act [2];
  logic [CW-1:0] m_cmp [2];
  logic [CW-1:0] m_shd [2];
  int            pos = 0;
  bit            dir = 1;

  always #(CLK_P/2) clk = ~clk;

  ocu_wave_gen #(.CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_up_i(up),
    .zero_i(zero), .peak_i(peak), .mode0_i(mode0), .mode1_i(mode1),
    .buf_en_i(buf_en), .xfer_peak_i(xfer_pk), .wr_en_i(wr_en),
    .wr_data0_i(wd0), .wr_data1_i(wd1), .rt0_o(rt0), .rt1_o(rt1)
  );

  function automatic logic [1:0] eff0(logic [1:0] m0, logic [1:0] m1);
    return (m1 == 2'b01 || m0 == 2'b01) ? 2'b00 : m0;
  endfunction

  function automatic logic next_act(logic [1:0] m, logic a, logic [CW-1:0] c,
                                    logic own, logic other, logic u, logic pk);
    if (!m[1]) return a ^ (own | ((m == 2'b01) & other));
    if (c == '0) return 1'b1;
    if (c == MAXV) return 1'b0;
    if (own && !pk) return u;
    return a;
  endfunction

  function automatic string tag_of(int ch, logic [1:0] m0, logic [1:0] m1,
                                   logic [CW-1:0] c);
    logic [1:0] m;
    m = (ch == 0) ? eff0(m0, m1) : m1;
    if (ch == 0 && m1 == 2'b01) return "R4";
    if (ch == 0 && m0 == 2'b01) return "R5";
    if (m == 2'b00) return "R2";
    if (m == 2'b01) return "R3";
    if (c == '0 || c == MAXV) return "R7";
    if (m == 2'b11) return "R8";
    return "R6";
  endfunction

  task automatic check(string tag, int ch, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s ch%0d cnt=%0d: got %b expected %b",
               tag, phase, ch, cnt, act, exp);
    end
  endtask

  // one clock: present count and writes, advance model, sample at next negedge
  task automatic cycle(logic [1:0] w, logic [CW-1:0] d0, logic [CW-1:0] d1);
    logic [CW-1:0] c;
    logic n0, n1, mt0, mt1, ev;
    string t0, t1;
    if (pos == 0) dir = 1;
    if (pos == PEAK) dir = 0;
    c = CW'(pos);
    cnt = c; up = dir; zero = (pos == 0); peak = (pos == PEAK);
    wr_en = w; wd0 = d0; wd1 = d1;
    mt0 = (c == m_cmp[0]); mt1 = (c == m_cmp[1]);
    n0 = next_act(eff0(mode0, mode1), m_act[0], m_cmp[0], mt0, 1'b0, up, peak);
    n1 = next_act(mode1, m_act[1], m_cmp[1], mt1, mt0, up, peak);
    t0 = tag_of(0, mode0, mode1, m_cmp[0]);
    t1 = tag_of(1, mode0, mode1, m_cmp[1]);
    for (int k = 0; k < 2; k++) begin
      logic [CW-1:0] dk;
      logic [CW-1:0] old;
      dk  = (k == 0) ? d0 : d1;
      old = m_shd[k];
      if (w[k]) m_shd[k] = dk;
      ev = buf_en[k] & (xfer_pk[k] ? peak : zero);
      if (w[k] && !buf_en[k]) m_cmp[k] = dk;
      else if (ev) m_cmp[k] = w[k] ? dk : old;
    end
    m_act[0] = n0; m_act[1] = n1;
    if (dir) pos++; else pos--;
    @(posedge clk);
    @(negedge clk);
    wr_en = 2'b00;
    check(t0, 0, rt0, m_act[0] ^ (eff0(mode0, mode1) == 2'b11));
    check(t1, 1, rt1, m_act[1] ^ (mode1 == 2'b11));
  endtask

  function automatic logic [CW-1:0] rnd_cmp();
    int r;
    r = $urandom_range(0, 15);
    if (r == 0) return '0;
    if (r == 1) return MAXV;
    return CW'($urandom_range(0, PEAK));
  endfunction

  task automatic run(int n, int wprob);
    for (int i = 0; i < n; i++) begin
      logic [1:0] w;
      w[0] = ($urandom_range(0, 99) < wprob);
      w[1] = ($urandom_range(0, 99) < wprob);
      cycle(w, rnd_cmp(), rnd_cmp());
    end
  endtask

  task automatic set_cmp(logic [CW-1:0] a, logic [CW-1:0] b);
    logic [1:0] sb;
    sb = buf_en;
    buf_en = 2'b00;
    cycle(2'b11, a, b); // R9 direct write
    buf_en = sb;
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c0));
    for (int k = 0; k < 2; k++) begin
      m_act[k] = 0; m_cmp[k] = '0; m_shd[k] = '0;
    end
    // R1 reset state in each level polarity
    #(CLK_P * 2);
    @(negedge clk);
    phase = "reset";
    check("R1", 0, rt0, 1'b0);
    check("R1", 1, rt1, 1'b0);
    mode0 = 2'b11; mode1 = 2'b11;
    #1;
    check("R1", 0, rt0, 1'b1);
    check("R1", 1, rt1, 1'b1);
    mode0 = 2'b10; mode1 = 2'b10;
    @(negedge clk);
    rst_n = 1'b1;
    // R1/R7 compare resets to 0x0000: up/down forces active next cycle
    phase = "reset_cmp";
    cycle(2'b00, '0, '0);

    // R8 mode change alters level without a clock
    phase = "level";
    mode0 = 2'b11;
    #1;
    check("R8", 0, rt0, 1'b0);
    mode0 = 2'b10;

    // all mode pairs, direct writes
    phase = "modes";
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        mode0 = 2'(a); mode1 = 2'(b);
        set_cmp(CW'($urandom_range(1, PEAK)), CW'($urandom_range(1, PEAK)));
        run(2 * (2 * PEAK), 0);
        run(2 * PEAK, 4);
      end
    end

    // R3 equal compare values toggle once
    phase = "dual_equal";
    mode0 = 2'b00; mode1 = 2'b01;
    set_cmp(CW'(7), CW'(7));
    run(3 * PEAK, 0);
    set_cmp(CW'(5), CW'(PEAK));
    run(3 * PEAK, 0);

    // R4 ch0 up/down mode ignored while ch1 is two-change
    phase = "tied";
    mode0 = 2'b11;
    set_cmp(CW'(9), CW'(3));
    run(3 * PEAK, 0);

    // R6 match on the peak count holds
    phase = "peak_hold";
    mode0 = 2'b10; mode1 = 2'b11;
    set_cmp(CW'(PEAK), CW'(PEAK));
    run(3 * PEAK, 0);

    // R7 saturating values
    phase = "sat";
    set_cmp('0, MAXV);
    run(2 * PEAK, 0);
    set_cmp(MAXV, '0);
    run(2 * PEAK, 0);

    // R10 buffered, zero then peak transfer points
    for (int s = 0; s < 4; s++) begin
      phase = (s[0]) ? "R10_peak" : "R10_zero";
      buf_en = 2'b11; xfer_pk = {s[1] ^ s[0], s[0]};
      mode0 = 2'(s); mode1 = 2'(3 - s);
      run(6 * PEAK, 10);
      // write landing on the transfer cycle itself
      while (pos != (xfer_pk[0] ? PEAK : 0)) cycle(2'b00, '0, '0);
      cycle(2'b11, CW'(4), CW'(11));
      run(3 * PEAK, 0);
    end
    buf_en = 2'b00;

    // mixed random tail
    phase = "random";
    for (int i = 0; i < 40; i++) begin
      mode0 = 2'($urandom_range(0, 3)); mode1 = 2'($urandom_range(0, 3));
      buf_en = 2'($urandom_range(0, 3)); xfer_pk = 2'($urandom_range(0, 3));
      run(PEAK, 15);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule